// File: doc/BRIEF.md
# Decimal Edit Engine

The engine formats a packed decimal number into a printable field. A caller holds a pattern in a byte buffer and the engine walks that buffer from index 0 up to a given last index, one byte per clock. For each byte it reads the pattern byte and writes a result byte back to the same index, so the pattern is overwritten in place. The first byte is kept unchanged and becomes the fill character. Three control codes in the pattern decide where source digits go, and a significance flag decides whether each position shows a digit, the pattern literal, or the fill character.

The source number is presented as a wide vector at the start pulse and is held inside the engine. Digits are taken from it in order, most significant first, and sign nibbles are examined on the way. When the walk ends, the engine raises `done` for one cycle and shows a two-bit condition code that describes the last field of the source.

The controller has four named states. `IDLE` waits for `start`; the transition `IDLE -> LOAD_FILL` happens on an accepted start. `LOAD_FILL` reads pattern byte 0, writes it back and latches it as fill; it goes to `FINISH` when the last index is 0, otherwise to `WALK`. `WALK` handles one pattern byte per cycle and stays there until the byte at the last index has been handled, then goes to `FINISH`. `FINISH` pulses `done` and returns to `IDLE`.

Top module: `decimal_edit_engine`

## Requirements
- R1: A `start` in `IDLE` latches the source, the last index and the mode; in the next cycle byte 0 is read, written back unchanged and kept as the fill character.
- R2: Pattern bytes are handled at indices 0, 1, ... up to `pat_last`, one per cycle with `wr_en` high; `done` is high for exactly one cycle, the cycle after the last write, and `busy` is high from the first write through the `done` cycle.
- R3: Pattern byte 0x20 selects a digit: it consumes one source digit and writes that digit if significance is on or the digit is nonzero; otherwise it writes the fill character.
- R4: Significance is off when a run begins, turns on when a nonzero digit is consumed, and stays on until a separator or a positive sign turns it off.
- R5: Pattern byte 0x21 turns significance on at its own position, consumes a source digit and always writes it, so zeros from there on are shown.
- R6: Pattern byte 0x22 writes the fill character, turns significance off, consumes no digit and restarts condition-code tracking.
- R7: Any other pattern byte consumes no digit; it is written unchanged if significance is on and replaced by the fill character if it is off.
- R8: A digit is written with the digit in bits 3:0 and zone 0xF in bits 7:4 when `ascii_mode` is 0, or zone 0x5 when it is 1.
- R9: Source byte k sits in `src_data[8k+7:8k]`, byte 0 being most significant; digits are taken high nibble then low nibble; a low nibble above 9 is a sign and is skipped; past the last source byte the digits read as 0.
- R10: A sign is examined in the cycle that consumes the digit to its left; signs 0xA, 0xC, 0xE, 0xF are positive and turn significance off after that position; 0xB and 0xD are negative.
- R11: At `done`, `cc` is 00 if no nonzero digit was consumed after the last separator, else 10 if the last sign consumed after it was positive, else 01 (negative or no sign).
- R12: A `start` while `busy` is high is ignored; the run in progress continues unchanged.
- R13: After reset the engine is idle: `busy`, `done` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| ascii_mode | input | 1 | 1 selects zone 0x5 for digits, 0 selects 0xF |
| pat_last | input | AW | Index of the last pattern byte |
| src_data | input | 8*SRC_BYTES | Packed decimal source, byte 0 in the low bits |
| pat_addr | output | AW | Pattern index being read and written this cycle |
| pat_rdata | input | 8 | Pattern byte at `pat_addr` (combinational read) |
| wr_en | output | 1 | Write `wr_data` to `pat_addr` this cycle |
| wr_data | output | 8 | Result byte |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the last write |
| cc | output | 2 | Condition code, valid with `done` |

## Verification
Digit-select fields over sources with leading zeros separate zero suppression from significance turn-on, and a significance-start byte placed before the zeros shows whether they are kept. Multi-field patterns with separators and signs of both polarities tell apart the separator's reset of significance, the sign's reset, and the per-field condition code, while an all-zero source and an unsigned source split codes 00 and 01. A source with no sign and more digit selects than digits exercises running past the source end, the same field in both modes checks the zone, and a one-byte pattern and a start pulse mid-run cover the shortest run and the ignored start.

// File: rtl/edit_pkg.sv
package edit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD_FILL,
        ST_WALK,
        ST_FINISH
    } edit_state_e;

    typedef enum logic [1:0] {
        PK_LIT,
        PK_DIGIT,
        PK_SIGSTART,
        PK_SEP
    } pat_kind_e;

    localparam logic [7:0] PB_DIGIT    = 8'h20;
    localparam logic [7:0] PB_SIGSTART = 8'h21;
    localparam logic [7:0] PB_SEP      = 8'h22;

    localparam logic [3:0] ZONE_EBCDIC = 4'hF;
    localparam logic [3:0] ZONE_ASCII  = 4'h5;

    localparam logic [1:0] CC_ZERO = 2'b00;
    localparam logic [1:0] CC_NEG  = 2'b01;
    localparam logic [1:0] CC_POS  = 2'b10;

    function automatic logic sign_is_positive(input logic [3:0] s);
        return (s == 4'hA) || (s == 4'hC) || (s == 4'hE) || (s == 4'hF);
    endfunction

endpackage

// File: rtl/edit_src_cursor.sv
module edit_src_cursor
    import edit_pkg::*;
#(
    parameter int SRC_BYTES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [8*SRC_BYTES-1:0] src_in,
    input  logic                   take,
    output logic [3:0]             digit,
    output logic                   sign_valid,
    output logic                   sign_positive
);

    localparam int SRC_W = 8 * SRC_BYTES;
    localparam int PW    = $clog2(SRC_BYTES + 1);
    localparam logic [PW-1:0] PTR_END = PW'(SRC_BYTES);

    logic [SRC_W-1:0] src_q;
    logic [PW-1:0]    byte_q;
    logic             low_q;
    logic [7:0]       cur_byte;
    logic             in_range;
    logic [PW-1:0]    byte_next;

    assign in_range  = (byte_q < PTR_END);
    assign byte_next = in_range ? byte_q + PW'(1) : byte_q;

    always_comb begin
        cur_byte = '0;
        for (int k = 0; k < SRC_BYTES; k++) begin
            if (byte_q == PW'(k)) begin
                cur_byte = src_q[8*k +: 8];
            end
        end
    end

    assign digit         = low_q ? cur_byte[3:0] : cur_byte[7:4];
    assign sign_valid    = !low_q && (cur_byte[3:0] > 4'd9);
    assign sign_positive = sign_is_positive(cur_byte[3:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            byte_q <= '0;
            low_q  <= 1'b0;
        end else if (load) begin
            src_q  <= src_in;
            byte_q <= '0;
            low_q  <= 1'b0;
        end else if (take) begin
            if (low_q || sign_valid) begin
                byte_q <= byte_next;
                low_q  <= 1'b0;
            end else begin
                low_q  <= 1'b1;
            end
        end
    end

    // R9
    ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_q <= PTR_END);

    // R9
    sign_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !load && sign_valid) |=> !low_q);

    // R9
    high_then_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !load && !low_q && !sign_valid) |=> low_q);

endmodule

// File: rtl/edit_byte_decide.sv
module edit_byte_decide
    import edit_pkg::*;
(
    input  logic [7:0] pat_byte,
    input  logic [7:0] fill,
    input  logic       sig,
    input  logic [3:0] digit,
    input  logic       ascii,
    output pat_kind_e  kind,
    output logic       take,
    output logic [7:0] out_byte,
    output logic       sig_mid
);

    logic [3:0] zone;
    logic [7:0] digit_byte;
    logic       nonzero;

    assign zone       = ascii ? ZONE_ASCII : ZONE_EBCDIC;
    assign digit_byte = {zone, digit};
    assign nonzero    = (digit != 4'd0);

    always_comb begin
        if (pat_byte == PB_DIGIT)          kind = PK_DIGIT;
        else if (pat_byte == PB_SIGSTART)  kind = PK_SIGSTART;
        else if (pat_byte == PB_SEP)       kind = PK_SEP;
        else                               kind = PK_LIT;
    end

    always_comb begin
        take     = 1'b0;
        out_byte = fill;
        sig_mid  = sig;
        unique case (kind)
            PK_DIGIT: begin
                take     = 1'b1;
                out_byte = (sig || nonzero) ? digit_byte : fill;
                sig_mid  = sig || nonzero;
            end
            PK_SIGSTART: begin
                take     = 1'b1;
                out_byte = digit_byte;
                sig_mid  = 1'b1;
            end
            PK_SEP: begin
                out_byte = fill;
                sig_mid  = 1'b0;
            end
            PK_LIT: begin
                out_byte = sig ? pat_byte : fill;
                sig_mid  = sig;
            end
            default: begin
                out_byte = fill;
            end
        endcase
    end

endmodule

// File: rtl/edit_cc_track.sv
module edit_cc_track
    import edit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       digit_take,
    input  logic [3:0] digit,
    input  logic       sign_take,
    input  logic       sign_pos,
    output logic [1:0] cc
);

    logic nz_q;
    logic pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nz_q  <= 1'b0;
            pos_q <= 1'b0;
        end else if (clear) begin
            nz_q  <= 1'b0;
            pos_q <= 1'b0;
        end else begin
            if (digit_take && (digit != 4'd0)) nz_q <= 1'b1;
            if (sign_take) pos_q <= sign_pos;
        end
    end

    always_comb begin
        if (!nz_q)      cc = CC_ZERO;
        else if (pos_q) cc = CC_POS;
        else            cc = CC_NEG;
    end

    // R6
    sep_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cc == CC_ZERO));

    // R11
    nonzero_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && digit_take && (digit != 4'd0)) |=> (cc != CC_ZERO));

endmodule

// File: rtl/decimal_edit_engine.sv
module decimal_edit_engine
    import edit_pkg::*;
#(
    parameter int SRC_BYTES = 8,
    parameter int PAT_MAX   = 32,
    localparam int AW       = $clog2(PAT_MAX),
    localparam int SRC_W    = 8 * SRC_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ascii_mode,
    input  logic [AW-1:0]    pat_last,
    input  logic [SRC_W-1:0] src_data,
    output logic [AW-1:0]    pat_addr,
    input  logic [7:0]       pat_rdata,
    output logic             wr_en,
    output logic [7:0]       wr_data,
    output logic             busy,
    output logic             done,
    output logic [1:0]       cc
);

    edit_state_e state_q, state_d;

    logic [AW-1:0] idx_q;
    logic [AW-1:0] last_q;
    logic [7:0]    fill_q;
    logic          sig_q;
    logic          ascii_q;

    logic          accept;
    logic          in_walk;
    logic [3:0]    cur_digit;
    logic          sign_valid;
    logic          sign_positive;
    pat_kind_e     kind;
    logic          dec_take;
    logic [7:0]    dec_out;
    logic          sig_mid;
    logic          take;
    logic          sign_off;
    logic          sig_d;
    logic          cc_clear;

    assign accept   = (state_q == ST_IDLE) && start;
    assign in_walk  = (state_q == ST_WALK);
    assign take     = in_walk && dec_take;
    assign sign_off = take && sign_valid && sign_positive;
    assign sig_d    = sign_off ? 1'b0 : sig_mid;
    assign cc_clear = accept || (in_walk && (kind == PK_SEP));

    edit_src_cursor #(
        .SRC_BYTES(SRC_BYTES)
    ) u_cursor (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (accept),
        .src_in       (src_data),
        .take         (take),
        .digit        (cur_digit),
        .sign_valid   (sign_valid),
        .sign_positive(sign_positive)
    );

    edit_byte_decide u_decide (
        .pat_byte(pat_rdata),
        .fill    (fill_q),
        .sig     (sig_q),
        .digit   (cur_digit),
        .ascii   (ascii_q),
        .kind    (kind),
        .take    (dec_take),
        .out_byte(dec_out),
        .sig_mid (sig_mid)
    );

    edit_cc_track u_cc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cc_clear),
        .digit_take(take),
        .digit     (cur_digit),
        .sign_take (take && sign_valid),
        .sign_pos  (sign_positive),
        .cc        (cc)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept) state_d = ST_LOAD_FILL;
            ST_LOAD_FILL: state_d = (last_q == '0) ? ST_FINISH : ST_WALK;
            ST_WALK:      if (idx_q == last_q) state_d = ST_FINISH;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            last_q  <= '0;
            fill_q  <= '0;
            sig_q   <= 1'b0;
            ascii_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        idx_q   <= '0;
                        last_q  <= pat_last;
                        ascii_q <= ascii_mode;
                        sig_q   <= 1'b0;
                    end
                end
                ST_LOAD_FILL: begin
                    fill_q <= pat_rdata;
                    idx_q  <= idx_q + AW'(1);
                end
                ST_WALK: begin
                    sig_q <= sig_d;
                    if (idx_q != last_q) idx_q <= idx_q + AW'(1);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        pat_addr = idx_q;
        wr_en    = 1'b0;
        wr_data  = dec_out;
        busy     = (state_q != ST_IDLE);
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_LOAD_FILL: begin
                wr_en   = 1'b1;
                wr_data = pat_rdata;
            end
            ST_WALK:      wr_en = 1'b1;
            ST_FINISH:    done  = 1'b1;
            default:      ;
        endcase
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_walk && (idx_q != last_q)) |=> (pat_addr == $past(pat_addr) + AW'(1)));

    // R2
    finish_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_walk && (idx_q == last_q)) |=> done);

    // R4
    sig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_walk && sig_q && (kind != PK_SEP) && !sign_off) |=> sig_q);

    // R12
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> busy);

endmodule

// File: tb/decimal_edit_engine_bench.sv
module decimal_edit_engine_bench;

    localparam int SB    = 8;
    localparam int PMAX  = 32;
    localparam int AW    = $clog2(PMAX);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            ascii_mode = 1'b0;
    logic [AW-1:0]   pat_last = '0;
    logic [8*SB-1:0] src_data = '0;
    logic [AW-1:0]   pat_addr;
    logic [7:0]      pat_rdata;
    logic            wr_en;
    logic [7:0]      wr_data;
    logic            busy;
    logic            done;
    logic [1:0]      cc;

    logic [7:0] pmem [PMAX];
    logic [7:0] pat_q [$];
    logic [7:0] exp_q [$];
    int         exp_cc;
    int         total = 0;
    int         bad = 0;

    always #10 clk = ~clk;

    assign pat_rdata = pmem[pat_addr];

    always @(posedge clk) begin
        if (wr_en) pmem[wr_addr_of(pat_addr)] <= wr_data;
    end

    function automatic int wr_addr_of(input logic [AW-1:0] a);
        return int'(a);
    endfunction

    decimal_edit_engine #(.SRC_BYTES(SB), .PAT_MAX(PMAX)) u_decimal_edit_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .ascii_mode(ascii_mode),
        .pat_last(pat_last), .src_data(src_data), .pat_addr(pat_addr),
        .pat_rdata(pat_rdata), .wr_en(wr_en), .wr_data(wr_data),
        .busy(busy), .done(done), .cc(cc)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int idx, input logic [7:0] b);
        if (idx == 0)     return "R1 fill byte";
        if (b == 8'h20)   return "R3 digit select";
        if (b == 8'h21)   return "R5 significance start";
        if (b == 8'h22)   return "R6 separator";
        return "R7 literal";
    endfunction

    // Behavioural reference: walks pat_q with integer cursors, fills exp_q and exp_cc.
    task automatic model(input bit ascii, input logic [8*SB-1:0] src);
        int  ptr = 0;
        bit  sig = 0;
        bit  nz = 0;
        bit  pos = 0;
        logic [7:0] fill = pat_q[0];
        exp_q = {};
        exp_q.push_back(pat_q[0]);
        for (int i = 1; i < pat_q.size(); i++) begin
            logic [7:0] b = pat_q[i];
            if (b == 8'h22) begin
                exp_q.push_back(fill);
                sig = 0; nz = 0; pos = 0;
            end else if (b == 8'h20 || b == 8'h21) begin
                int d = 0;
                int s = -1;
                if (ptr < 2*SB) begin
                    int bi = ptr / 2;
                    int lo = int'(src[8*bi +: 4]);
                    if (ptr % 2 == 0) begin
                        d = int'(src[8*bi+4 +: 4]);
                        if (lo > 9) begin s = lo; ptr += 2; end
                        else ptr += 1;
                    end else begin
                        d = lo;
                        ptr += 1;
                    end
                end
                if (b == 8'h21) sig = 1;
                if (d != 0) begin sig = 1; nz = 1; end
                if (sig) exp_q.push_back({(ascii ? 4'h5 : 4'hF), 4'(d)});
                else     exp_q.push_back(fill);
                if (s >= 0) begin
                    pos = (s == 10 || s == 12 || s == 14 || s == 15);
                    if (pos) sig = 0;
                end
            end else begin
                exp_q.push_back(sig ? b : fill);
            end
        end
        exp_cc = !nz ? 0 : (pos ? 2 : 1);
    endtask

    task automatic run_case(input bit ascii, input logic [8*SB-1:0] src, input bit poke);
        int last = pat_q.size() - 1;
        for (int i = 0; i < PMAX; i++) pmem[i] = 8'h00;
        for (int i = 0; i <= last; i++) pmem[i] = pat_q[i];
        model(ascii, src);
        @(negedge clk);
        start = 1'b1; ascii_mode = ascii; src_data = src; pat_last = AW'(last);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= last; k++) begin
            chk(wr_en === 1'b1, "R2 write enable", int'(wr_en), 1);
            chk(pat_addr === AW'(k), "R2 address order", int'(pat_addr), k);
            chk(wr_data === exp_q[k], tag_of(k, pat_q[k]), int'(wr_data), int'(exp_q[k]));
            chk(done === 1'b0 && busy === 1'b1, "R2 busy during walk", int'({busy, done}), 2);
            if (poke && k == 1) begin
                // R12: start while busy, with a different source and mode
                start = 1'b1; src_data = ~src; ascii_mode = ~ascii; pat_last = '0;
            end
            @(negedge clk);
            start = 1'b0;
        end
        chk(done === 1'b1, "R2 done pulse", int'(done), 1);
        chk(wr_en === 1'b0, "R2 no write at done", int'(wr_en), 0);
        chk(int'(cc) == exp_cc, "R11 condition code", int'(cc), exp_cc);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R2 back to idle", int'({busy, done}), 0);
        for (int i = 0; i <= last; i++)
            chk(pmem[i] === exp_q[i], "R1 buffer after run", int'(pmem[i]), int'(exp_q[i]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired");
        total++; bad++;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(busy === 1'b0 && done === 1'b0 && wr_en === 1'b0, "R13 reset idle",
            int'({busy, done, wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && wr_en === 1'b0, "R13 idle after reset", int'({busy, wr_en}), 0);

        // R3 R4 R9 R10: grouped field, leading zeros suppressed, digits 0 0 0 1 2 3 4
        pat_q = {8'h40, 8'h20, 8'h20, 8'h6B, 8'h20, 8'h20, 8'h20, 8'h4B, 8'h20, 8'h20};
        run_case(1'b0, {24'h0, 8'h6C, 8'h45, 8'h23, 8'h01, 8'h00}, 1'b0);

        // R8: same field in the other zone mode
        run_case(1'b1, {24'h0, 8'h6C, 8'h45, 8'h23, 8'h01, 8'h00}, 1'b0);

        // R5 R10: significance start keeps zeros, negative sign gives 01 (R11)
        pat_q = {8'h5C, 8'h20, 8'h21, 8'h20, 8'h4B, 8'h20, 8'h20};
        run_case(1'b0, {40'h0, 8'h7D, 8'h0D, 8'h00}, 1'b0);

        // R6 R10 R11: two fields, positive sign ends significance, code from last field
        pat_q = {8'h40, 8'h20, 8'h20, 8'h1C, 8'h22, 8'h20, 8'h20, 8'h20, 8'h60};
        run_case(1'b0, {32'h0, 8'h5D, 8'h34, 8'h2C, 8'h01}, 1'b0);

        // R6 R11: second field negative after a positive first field
        pat_q = {8'h2A, 8'h20, 8'h20, 8'h22, 8'h20, 8'h20, 8'h20, 8'h6B};
        run_case(1'b1, {32'h0, 8'h00, 8'h7D, 8'h05, 8'h3C}, 1'b0);

        // R11: all-zero source gives 00 and every position fill; R7 literals replaced
        pat_q = {8'h5C, 8'h20, 8'h4B, 8'h20, 8'h20, 8'h60};
        run_case(1'b0, {48'h0, 8'h0C, 8'h00}, 1'b0);

        // R9: no sign anywhere, more digit selects than digits, tail reads as zero
        pat_q = {8'h40};
        for (int i = 0; i < 20; i++) pat_q.push_back(8'h20);
        run_case(1'b0, {8{8'h98}}, 1'b0);

        // R2: single-byte pattern, only the fill byte
        pat_q = {8'h7E};
        run_case(1'b0, 64'h1C, 1'b0);

        // R7 R12: literals around digits, start pulse mid-run ignored
        pat_q = {8'h40, 8'h41, 8'h20, 8'h42, 8'h20, 8'h20, 8'h43, 8'h21, 8'h20, 8'h44};
        run_case(1'b0, {40'h0, 8'h9F, 8'h00, 8'h03}, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule